// File: doc/BRIEF.md
# DRAM Self-Refresh Burst Sequencer

This block sits on the controller side of an asynchronous DRAM. It moves the memory from normal traffic into self-refresh and back again without letting any row go stale. When the host asks for self-refresh, the sequencer takes the bus and runs a refresh burst that covers every row. Each refresh cycle is either CAS-before-RAS, where the device supplies the row, or RAS-only, where the block drives the row from its own counter. It then drops CAS and RAS to enter self-refresh and holds RAS low. When the host withdraws the request, and the minimum hold time has passed, it lifts RAS and then CAS. It waits one precharge interval, runs a second full burst, and only then hands the bus back with a one-clock acknowledge.

All intervals are counted in clock cycles that come from parameters. Each burst mode has its own pair of limits. The entry limit bounds the time from the first burst RAS fall to the RAS fall that starts self-refresh. The exit limit bounds the time from the RAS rise that ends self-refresh to the RAS fall of the last burst cycle. If the elapsed count passes the limit for the active mode, a sticky error flag is raised.

Top module: `dram_srf_seq`

## Requirements
- R1: After reset, ras_n and cas_n are high, and srf_ack, host_block and window_err are low.
- R2: A burst has exactly 2^ROW_BITS refresh cycles. A CAS-before-RAS cycle drives cas_n low with ras_n high for 1 clock. It then drives both low for T_RAS_CYC clocks. It then drives both high for T_RP_CYC clocks.
- R3: A RAS-only cycle drives ras_n low for T_RAS_CYC clocks with cas_n high, then both high for T_RP_CYC clocks. row_addr carries the row at each RAS fall. Rows run 0, 1, … 2^ROW_BITS-1 in every burst, and the counter restarts at 0 for each burst and wraps after the top row.
- R4: Entry into self-refresh drives cas_n low with ras_n high for 1 clock, then both low. RAS stays low for at least SRF_MIN_CYC clocks, and for as long as srf_req stays high.
- R5: Exit from self-refresh raises ras_n first, with cas_n low for 1 clock. Both lines are then high for T_RP_CYC clocks before the exit burst starts.
- R6: host_block goes high in the clock after a request is accepted and stays high until the exit burst ends. Every clock with ras_n low has host_block high.
- R7: srf_ack is a one-clock pulse with host_block low. It starts T_RAS_CYC+T_RP_CYC clocks after the RAS fall of the last exit-burst cycle.
- R8: The entry interval runs from the first burst RAS fall to the self-refresh RAS fall. It is N·(1+T_RAS+T_RP) clocks in CAS-before-RAS mode and N·(T_RAS+T_RP)+1 in RAS-only mode. window_err is set if it exceeds the mode's entry limit, and stays set until reset.
- R9: The exit interval runs from the self-refresh RAS rise to the last exit-burst RAS fall. It is 2+T_RP+(N-1)·(1+T_RAS+T_RP) clocks in CAS-before-RAS mode and 1+T_RP+(N-1)·(T_RAS+T_RP) in RAS-only mode. window_err is set if it exceeds the mode's exit limit.
- R10: mode_row_only (1 = RAS-only, 0 = CAS-before-RAS) is sampled only when a request is accepted. Changes during a sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srf_req | input | 1 | Host holds high to request and stay in self-refresh |
| mode_row_only | input | 1 | Burst mode at acceptance: 1 RAS-only, 0 CAS-before-RAS |
| srf_ack | output | 1 | One-clock pulse when the exit burst has completed |
| host_block | output | 1 | High while normal traffic must stay off the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_BITS | Row driven during RAS-only cycles |
| window_err | output | 1 | Sticky flag: entry or exit interval exceeded its limit |

## Verification
The embedded assertions check these properties on every cycle:
- CAS leads every CAS-before-RAS strobe.
- RAS-only rows advance by one from fall to fall.
- The row counter wraps to zero.
- Self-refresh lasts at least the minimum hold.
- RAS never falls without host_block.
- The acknowledge is a lone pulse after both strobes are high.
- The error flag never clears.

Only the bench scenarios can show the rest. These are the exact count and order of burst cycles around self-refresh, and the restart of the row sequence. They also cover the measured entry and exit intervals against limits set exactly at and one below those intervals. Finally, they show the hold lasting until the request drops, and a mode change during a sequence being ignored.

// File: rtl/dram_srf_pkg.sv
package dram_srf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAS_SETUP,
        ST_RAS_ACT,
        ST_PRECHARGE,
        ST_SR_CAS,
        ST_SR_HOLD,
        ST_SR_RISE,
        ST_SR_PRE,
        ST_DONE
    } seq_state_e;

    typedef enum logic {
        MODE_CBR = 1'b0,
        MODE_ROW = 1'b1
    } burst_mode_e;

    typedef enum logic {
        LEG_ENTRY = 1'b0,
        LEG_EXIT  = 1'b1
    } leg_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic busy;
        logic ack;
    } strobe_t;

    // Clock cycles in a span given in tenths of a millisecond.
    function automatic int tenth_ms_to_cyc(int clk_khz, int tenths);
        return (clk_khz * tenths) / 10;
    endfunction

    function automatic strobe_t decode_strobes(seq_state_e s, burst_mode_e m);
        strobe_t o;
        o = '{ras_n: 1'b1, cas_n: 1'b1, busy: 1'b1, ack: 1'b0};
        case (s)
            ST_IDLE:      o.busy = 1'b0;
            ST_CAS_SETUP: o.cas_n = 1'b0;
            ST_RAS_ACT: begin
                o.ras_n = 1'b0;
                o.cas_n = (m == MODE_ROW);
            end
            ST_PRECHARGE: o.busy = 1'b1;
            ST_SR_CAS:    o.cas_n = 1'b0;
            ST_SR_HOLD: begin
                o.ras_n = 1'b0;
                o.cas_n = 1'b0;
            end
            ST_SR_RISE:   o.cas_n = 1'b0;
            ST_SR_PRE:    o.busy = 1'b1;
            ST_DONE: begin
                o.busy = 1'b0;
                o.ack  = 1'b1;
            end
            default:      o.busy = 1'b0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dram_srf_dwell.sv
module dram_srf_dwell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_srf_rowctr.sv
module dram_srf_rowctr #(
    parameter int ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                step,
    output logic [ROW_BITS-1:0] row,
    output logic                wrapped
);
    logic at_last;
    assign at_last = (row == {ROW_BITS{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row     <= '0;
            wrapped <= 1'b0;
        end else if (step) begin
            row <= row + 1'b1;
            if (at_last) wrapped <= 1'b1;
        end
    end

    // R3
    row_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_last && !clear) |=> (row == '0 && wrapped));

endmodule

// File: rtl/dram_srf_window.sv
module dram_srf_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] limit,
    output logic             overrun
);
    logic             on_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   nxt;

    assign nxt     = {1'b0, cnt_q} + 1'b1;
    assign overrun = on_q && (nxt > {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            on_q  <= 1'b1;
            cnt_q <= '0;
        end else if (on_q) begin
            if (!nxt[CNT_W]) cnt_q <= nxt[CNT_W-1:0];
            if (stop)        on_q  <= 1'b0;
        end
    end

    // R8 R9
    win_close_chk: assert property (@(posedge clk) disable iff (rst)
        (on_q && stop && !start) |=> !on_q);

endmodule

// File: rtl/dram_srf_seq.sv
module dram_srf_seq
    import dram_srf_pkg::*;
#(
    parameter int ROW_BITS      = 10,
    parameter int CLK_KHZ       = 100000,
    parameter int T_RAS_CYC     = 5,
    parameter int T_RP_CYC      = 4,
    parameter int SRF_MIN_CYC   = tenth_ms_to_cyc(CLK_KHZ, 1),
    parameter int CBR_ENTRY_CYC = tenth_ms_to_cyc(CLK_KHZ, 164),
    parameter int CBR_EXIT_CYC  = tenth_ms_to_cyc(CLK_KHZ, 164),
    parameter int RO_ENTRY_CYC  = tenth_ms_to_cyc(CLK_KHZ, 164),
    parameter int RO_EXIT_CYC   = tenth_ms_to_cyc(CLK_KHZ, 164)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                srf_req,
    input  logic                mode_row_only,
    output logic                srf_ack,
    output logic                host_block,
    output logic                ras_n,
    output logic                cas_n,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                window_err
);
    localparam int DW_A    = (T_RAS_CYC > T_RP_CYC) ? T_RAS_CYC : T_RP_CYC;
    localparam int DW_MAX  = (DW_A > SRF_MIN_CYC) ? DW_A : SRF_MIN_CYC;
    localparam int DW_W    = $clog2(DW_MAX + 1);
    localparam int WIN_A   = (CBR_ENTRY_CYC > CBR_EXIT_CYC) ? CBR_ENTRY_CYC : CBR_EXIT_CYC;
    localparam int WIN_B   = (RO_ENTRY_CYC > RO_EXIT_CYC) ? RO_ENTRY_CYC : RO_EXIT_CYC;
    localparam int WIN_MAX = (WIN_A > WIN_B) ? WIN_A : WIN_B;
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    localparam logic [DW_W-1:0] LD_ONE  = '0;
    localparam logic [DW_W-1:0] LD_RAS  = DW_W'(T_RAS_CYC - 1);
    localparam logic [DW_W-1:0] LD_RP   = DW_W'(T_RP_CYC - 1);
    localparam logic [DW_W-1:0] LD_HOLD = DW_W'(SRF_MIN_CYC - 1);

    seq_state_e  state_q, state_d;
    burst_mode_e mode_q, mode_d;
    leg_e        leg_q, leg_d;
    strobe_t     strb;

    logic            tmr_load, tmr_exp;
    logic [DW_W-1:0] tmr_val;
    logic                row_clear, row_step, row_wrapped, burst_begin;
    logic [ROW_BITS-1:0] row_q, row_eff;
    logic ras_fall_d, first_fall, last_fall;
    logic win_start, win_stop, win_over;
    logic [CNT_W-1:0] win_limit;
    logic err_q;

    // ---------------- sub-blocks ----------------
    dram_srf_dwell #(.W(DW_W)) u_dwell (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    dram_srf_rowctr #(.ROW_BITS(ROW_BITS)) u_rows (
        .clk(clk), .rst(rst), .clear(row_clear), .step(row_step),
        .row(row_q), .wrapped(row_wrapped)
    );

    dram_srf_window #(.CNT_W(CNT_W)) u_window (
        .clk(clk), .rst(rst), .start(win_start), .stop(win_stop),
        .limit(win_limit), .overrun(win_over)
    );

    // ---------------- sequencing ----------------
    always_comb begin
        state_d     = state_q;
        mode_d      = mode_q;
        leg_d       = leg_q;
        tmr_load    = 1'b0;
        tmr_val     = LD_ONE;
        row_clear   = 1'b0;
        row_step    = 1'b0;
        burst_begin = 1'b0;
        case (state_q)
            ST_IDLE: if (srf_req) begin
                mode_d      = mode_row_only ? MODE_ROW : MODE_CBR;
                leg_d       = LEG_ENTRY;
                burst_begin = 1'b1;
                row_clear   = 1'b1;
                tmr_load    = 1'b1;
                if (mode_d == MODE_ROW) begin
                    state_d = ST_RAS_ACT;
                    tmr_val = LD_RAS;
                end else begin
                    state_d = ST_CAS_SETUP;
                end
            end
            ST_CAS_SETUP: if (tmr_exp) begin
                state_d  = ST_RAS_ACT;
                tmr_load = 1'b1;
                tmr_val  = LD_RAS;
            end
            ST_RAS_ACT: if (tmr_exp) begin
                state_d  = ST_PRECHARGE;
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
                row_step = 1'b1;
            end
            ST_PRECHARGE: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (row_wrapped) begin
                    state_d = (leg_q == LEG_ENTRY) ? ST_SR_CAS : ST_DONE;
                end else if (mode_q == MODE_ROW) begin
                    state_d = ST_RAS_ACT;
                    tmr_val = LD_RAS;
                end else begin
                    state_d = ST_CAS_SETUP;
                end
            end
            ST_SR_CAS: if (tmr_exp) begin
                state_d  = ST_SR_HOLD;
                tmr_load = 1'b1;
                tmr_val  = LD_HOLD;
            end
            ST_SR_HOLD: if (tmr_exp && !srf_req) begin
                state_d  = ST_SR_RISE;
                leg_d    = LEG_EXIT;
                tmr_load = 1'b1;
            end
            ST_SR_RISE: if (tmr_exp) begin
                state_d  = ST_SR_PRE;
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
            end
            ST_SR_PRE: if (tmr_exp) begin
                burst_begin = 1'b1;
                row_clear   = 1'b1;
                tmr_load    = 1'b1;
                if (mode_q == MODE_ROW) begin
                    state_d = ST_RAS_ACT;
                    tmr_val = LD_RAS;
                end else begin
                    state_d = ST_CAS_SETUP;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Row refreshed by the RAS fall taken at this edge, if any.
    assign row_eff    = burst_begin ? '0 : row_q;
    assign ras_fall_d = (state_d == ST_RAS_ACT) && (state_q != ST_RAS_ACT);
    assign first_fall = ras_fall_d && (row_eff == '0);
    assign last_fall  = ras_fall_d && (row_eff == {ROW_BITS{1'b1}});

    assign win_start = (first_fall && leg_d == LEG_ENTRY)
                     || (state_q == ST_SR_HOLD && state_d == ST_SR_RISE);
    assign win_stop  = (state_q == ST_SR_CAS && tmr_exp)
                     || (last_fall && leg_d == LEG_EXIT);

    always_comb begin
        case ({mode_q, leg_q})
            {MODE_CBR, LEG_ENTRY}: win_limit = CNT_W'(CBR_ENTRY_CYC);
            {MODE_CBR, LEG_EXIT}:  win_limit = CNT_W'(CBR_EXIT_CYC);
            {MODE_ROW, LEG_ENTRY}: win_limit = CNT_W'(RO_ENTRY_CYC);
            default:               win_limit = CNT_W'(RO_EXIT_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_CBR;
            leg_q    <= LEG_ENTRY;
            row_addr <= '0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            leg_q   <= leg_d;
            if (ras_fall_d) row_addr <= (mode_d == MODE_ROW) ? row_eff : '0;
            if (win_over)   err_q    <= 1'b1;
        end
    end

    assign strb       = decode_strobes(state_q, mode_q);
    assign ras_n      = strb.ras_n;
    assign cas_n      = strb.cas_n;
    assign host_block = strb.busy;
    assign srf_ack    = strb.ack;
    assign window_err = err_q;

    // ---------------- checks ----------------
    logic [DW_W-1:0]     low_run_q;
    logic [ROW_BITS-1:0] prev_ro_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q      <= '0;
            prev_ro_addr_q <= '0;
        end else begin
            if (ras_n)                               low_run_q <= '0;
            else if (low_run_q < DW_W'(SRF_MIN_CYC)) low_run_q <= low_run_q + 1'b1;
            if (!ras_n && cas_n)                     prev_ro_addr_q <= row_addr;
        end
    end

    // R2
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && mode_q == MODE_CBR) |-> (!cas_n && $past(cas_n) == 1'b0));

    // R3
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && cas_n && row_addr != '0) |-> (row_addr == prev_ro_addr_q + 1'b1));

    // R4
    sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ras_n) && !cas_n) |-> (low_run_q >= DW_W'(SRF_MIN_CYC)));

    // R6
    block_cover_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> host_block);

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        srf_ack |-> (!host_block && $past(ras_n) && $past(cas_n)) ##1 !srf_ack);

    // R8 R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        window_err |=> window_err);

endmodule

// File: tb/dram_srf_seq_test.sv
module dram_srf_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int RB     = 3;
    localparam int N      = 1 << RB;
    localparam int TRAS   = 3;
    localparam int TRP    = 2;
    localparam int SRMIN  = 20;
    localparam int CBR_EN = N * (1 + TRAS + TRP);
    localparam int CBR_EX = 2 + TRP + (N - 1) * (1 + TRAS + TRP);
    localparam int RO_EN  = N * (TRAS + TRP) + 1;
    localparam int RO_EX  = 1 + TRP + (N - 1) * (TRAS + TRP);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic srf_req = 1'b0;
    logic mode_row_only = 1'b0;
    logic srf_ack, host_block, ras_n, cas_n, window_err;
    logic [RB-1:0] row_addr;

    dram_srf_seq #(
        .ROW_BITS(RB), .T_RAS_CYC(TRAS), .T_RP_CYC(TRP), .SRF_MIN_CYC(SRMIN),
        .CBR_ENTRY_CYC(CBR_EN), .CBR_EXIT_CYC(CBR_EX),
        .RO_ENTRY_CYC(RO_EN), .RO_EXIT_CYC(RO_EX - 1)
    ) uut (
        .clk(clk), .rst(rst), .srf_req(srf_req), .mode_row_only(mode_row_only),
        .srf_ack(srf_ack), .host_block(host_block), .ras_n(ras_n), .cas_n(cas_n),
        .row_addr(row_addr), .window_err(window_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // kind: 0 CAS-before-RAS cycle, 1 RAS-only cycle, 2 self-refresh
    typedef struct { int kind; int row; } item_t;
    item_t expq[$];

    int cyc = 0;
    bit prev_ras = 1'b1;
    int fall_t, fall_cas, fall_addr, ev_idx;
    int t_first, t_sr_fall, t_sr_rise, t_last, t_ack;
    int sr_width, err_at_rise, ack_cnt = 0;

    // Monitor: samples at the falling clock edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (prev_ras && !ras_n) begin
                fall_t = cyc; fall_cas = cas_n; fall_addr = int'(row_addr);
                if (ev_idx == 0)     t_first   = cyc;
                if (ev_idx == N)     t_sr_fall = cyc;
                if (ev_idx == 2 * N) t_last    = cyc;
                ev_idx++;
            end
            if (!ras_n && prev_ras) check(host_block, "R6 block during RAS low", host_block, 1);
            if (!prev_ras && ras_n) begin
                int width, kind;
                item_t it;
                width = cyc - fall_t;
                kind = (width > TRAS) ? 2 : (fall_cas == 0 ? 0 : 1);
                if (kind == 2) begin
                    t_sr_rise = cyc; sr_width = width; err_at_rise = window_err;
                    check(!cas_n, "R5 CAS low after RAS rise", cas_n, 0);
                end else begin
                    check(width == TRAS, "R2 R3 RAS low width", width, TRAS);
                end
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected RAS cycle", kind, -1);
                end else begin
                    it = expq.pop_front();
                    check(kind == it.kind, "R2 R3 R4 R10 cycle kind", kind, it.kind);
                    if (it.kind == 1) check(fall_addr == it.row, "R3 row order", fall_addr, it.row);
                end
            end
            if (srf_ack) begin
                t_ack = cyc; ack_cnt++;
                check(!host_block, "R7 block low at ack", host_block, 0);
            end
            prev_ras = ras_n;
        end
    end

    // Driver: pushes the expected cycles, then runs one sequence.
    task automatic run_seq(input bit ro, input int req_clks, input int exp_en,
                           input int exp_ex, input int exp_w, input bit exp_err);
        int a0;
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < N; r++) expq.push_back('{ro ? 1 : 0, r});
            if (b == 0) expq.push_back('{2, 0});
        end
        a0 = ack_cnt;
        @(negedge clk); #1;
        ev_idx = 0;
        mode_row_only = ro;
        srf_req = 1'b1;
        @(negedge clk); #1;
        check(host_block, "R6 block after accept", host_block, 1);
        mode_row_only = !ro; // R10: must be ignored
        repeat (req_clks - 1) @(negedge clk);
        srf_req = 1'b0;
        wait (ack_cnt != a0);
        check(expq.size() == 0, "R2 all burst cycles seen", expq.size(), 0);
        check(t_sr_fall - t_first == exp_en, "R8 entry interval", t_sr_fall - t_first, exp_en);
        check(t_last - t_sr_rise == exp_ex, "R9 exit interval", t_last - t_sr_rise, exp_ex);
        check(sr_width == exp_w, "R4 self-refresh hold", sr_width, exp_w);
        check(t_ack - t_last == TRAS + TRP, "R7 ack latency", t_ack - t_last, TRAS + TRP);
        check(err_at_rise == 0, "R8 no entry overrun", err_at_rise, 0);
        check(window_err == exp_err, "R9 exit overrun flag", window_err, exp_err);
        @(negedge clk); #1;
        check(!srf_ack, "R7 ack one clock", srf_ack, 0);
        check(ras_n && cas_n && !host_block, "R7 bus released", {ras_n, cas_n, host_block}, 3'b110);
        mode_row_only = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        #1;
        check(ras_n && cas_n, "R1 strobes high in reset", {ras_n, cas_n}, 3);
        check(!srf_ack && !host_block && !window_err, "R1 flags low in reset",
              {srf_ack, host_block, window_err}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(ras_n && cas_n && !host_block, "R1 idle after reset",
              {ras_n, cas_n, host_block}, 3'b110);
        // CAS-before-RAS, request held long, limits exactly met
        run_seq(1'b0, 150, CBR_EN, CBR_EX, 101, 1'b0);
        // RAS-only, request dropped early, exit limit one short
        run_seq(1'b1, 4, RO_EN, RO_EX, SRMIN, 1'b1);
        repeat (10) @(negedge clk);
        #1;
        check(window_err, "R8 R9 flag sticky", window_err, 1);
        finish_run();
    end
endmodule